// File: doc/BRIEF.md
# 64-Point Radix-4 Cubed Streaming FFT Engine

This block computes a 64-point complex discrete Fourier transform on a continuous stream of fixed-point samples, one sample per clock. The transform runs as three radix-4 passes in a cascade, and each pass has its own butterfly circuit. The input index is split into three base-4 digits, n = 16·a + 4·b + c. The first pass combines the four samples that differ only in `a`. The second pass combines across `b` and the third across `c`. Between the passes the data is rotated by twiddle factors taken from a 16-entry and a 64-entry coefficient set. A small quarter-wave cosine table generates both sets.

Each pass owns a double-bank buffer. One bank takes the incoming frame while the other bank feeds the butterfly with four operands per cycle. Frames can therefore follow each other with no idle cycles. Every pass divides by four with rounding, so the engine delivers X[k]/64. Results leave in digit-reversed order, and each result carries its frequency index.

Top module: `fft64_r4_engine`

## Requirements
- R1: While reset is asserted, and after release until a frame has passed through, `out_valid` is 0 and `out_idx` is 0.
- R2: Each output equals (1/64)·Σₙ x[n]·e^(−j2πnk/64) within ±3 LSB on both the real and the imaginary part. Here n is the position of a sample among the 64 accepted samples of its frame, and k is the bin.
- R3: Within a frame, output j (j = 0..63 in emission order) is bin k = 16·j[1:0] + 4·j[3:2] + j[5:4]. `out_idx` carries that k.
- R4: Sample 0 of a frame may be captured at clock edge E, with that frame and the two before it accepted without gaps. Bin results of that frame then appear on the outputs after edge E+194, so `out_valid` is first seen high at edge E+195.
- R5: Frames accepted back to back produce a continuous `out_valid` of exactly 64 cycles per frame. Each frame's results depend only on its own samples, even while the next frame is being written.
- R6: Results saturate instead of wrapping. A frame of real +32767 gives bin 0 real part 32767. A frame of imaginary −32768 gives bin 0 imaginary part −32768. All other bins are 0.
- R7: A sample is taken only in a cycle with `in_valid` high. A frame boundary falls after every 64 accepted samples, counted from reset. Idle cycles inside or between frames do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_re | input | DATA_W | Signed real part of the input sample |
| in_im | input | DATA_W | Signed imaginary part of the input sample |
| out_valid | output | 1 | Result strobe |
| out_re | output | DATA_W | Signed real part of the bin result |
| out_im | output | DATA_W | Signed imaginary part of the bin result |
| out_idx | output | 6 | Frequency index k of the result |

## Verification
The bench uses the default DATA_W of 16 with 16-bit Q1.14 twiddles, so full-scale values of +32767 and −32768 can be applied directly. This makes the saturating rounding corners of R6 reachable. The fixed 64-point size lets three back-to-back frames overlap inside the three ping-pong stages, which exercises bank alternation and output continuity. Impulse, single-tone, pseudo-random and gapped frames are compared bin by bin against a real-valued DFT in the bench.

// File: rtl/fft64_r4_pkg.sv
package fft64_r4_pkg;
  localparam int PTS     = 64;
  localparam int IDX_W   = 6;
  localparam int NPASS   = 3;
  localparam int TW_W    = 16;
  localparam int TW_FRAC = 14;

  // cos(2*pi*i/64) in Q1.14 for i = 0..16
  function automatic logic signed [TW_W-1:0] qcos(input logic [4:0] i);
    case (i)
      5'd0:    qcos = 16'sd16384;
      5'd1:    qcos = 16'sd16305;
      5'd2:    qcos = 16'sd16069;
      5'd3:    qcos = 16'sd15679;
      5'd4:    qcos = 16'sd15137;
      5'd5:    qcos = 16'sd14449;
      5'd6:    qcos = 16'sd13623;
      5'd7:    qcos = 16'sd12665;
      5'd8:    qcos = 16'sd11585;
      5'd9:    qcos = 16'sd10394;
      5'd10:   qcos = 16'sd9102;
      5'd11:   qcos = 16'sd7723;
      5'd12:   qcos = 16'sd6270;
      5'd13:   qcos = 16'sd4756;
      5'd14:   qcos = 16'sd3196;
      5'd15:   qcos = 16'sd1606;
      default: qcos = 16'sd0;
    endcase
  endfunction

  // exp(-j*2*pi*e/64) packed as {re, im}
  function automatic logic [2*TW_W-1:0] tw64(input logic [5:0] e);
    logic signed [TW_W-1:0] cr, sr, c, s;
    cr = qcos({1'b0, e[3:0]});
    sr = qcos(5'd16 - {1'b0, e[3:0]});
    case (e[5:4])
      2'd0:    begin c = cr;  s = sr;  end
      2'd1:    begin c = -sr; s = cr;  end
      2'd2:    begin c = -cr; s = -sr; end
      default: begin c = sr;  s = -cr; end
    endcase
    tw64 = {c, -s};
  endfunction

  function automatic logic [IDX_W-1:0] digit_rev(input logic [IDX_W-1:0] k);
    digit_rev = {k[1:0], k[3:2], k[5:4]};
  endfunction
endpackage

// File: rtl/fft64_r4_bfly.sv
module fft64_r4_bfly #(
  parameter int DW = 16
) (
  input  logic [3:0][DW-1:0]   x_re,
  input  logic [3:0][DW-1:0]   x_im,
  input  logic [1:0]           k,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int SW = DW + 3;
  localparam logic signed [SW-1:0] HI = SW'(2**(DW-1) - 1);
  localparam logic signed [SW-1:0] LO = -SW'(2**(DW-1));

  logic signed [SW-1:0] acc_re, acc_im, ar, ai, sc_re, sc_im;
  logic [1:0] e;

  // one output bin per call: sum of W4 rotations, then /4 with rounding
  always_comb begin
    acc_re = '0;
    acc_im = '0;
    ar     = '0;
    ai     = '0;
    e      = '0;
    for (int m = 0; m < 4; m++) begin
      e  = 2'(m) * k;
      ar = SW'($signed(x_re[m]));
      ai = SW'($signed(x_im[m]));
      case (e)
        2'd0:    begin acc_re += ar; acc_im += ai; end
        2'd1:    begin acc_re += ai; acc_im -= ar; end
        2'd2:    begin acc_re -= ar; acc_im -= ai; end
        default: begin acc_re -= ai; acc_im += ar; end
      endcase
    end
    sc_re = (acc_re + SW'(2)) >>> 2;
    sc_im = (acc_im + SW'(2)) >>> 2;
    y_re  = (sc_re > HI) ? HI[DW-1:0] : (sc_re < LO) ? LO[DW-1:0] : sc_re[DW-1:0];
    y_im  = (sc_im > HI) ? HI[DW-1:0] : (sc_im < LO) ? LO[DW-1:0] : sc_im[DW-1:0];
  end
endmodule

// File: rtl/fft64_r4_cmul.sv
module fft64_r4_cmul #(
  parameter int DW      = 16,
  parameter int TW_W    = 16,
  parameter int TW_FRAC = 14
) (
  input  logic signed [DW-1:0]   a_re,
  input  logic signed [DW-1:0]   a_im,
  input  logic signed [TW_W-1:0] w_re,
  input  logic signed [TW_W-1:0] w_im,
  output logic signed [DW-1:0]   p_re,
  output logic signed [DW-1:0]   p_im
);
  localparam int PW = DW + TW_W + 1;
  localparam logic signed [PW-1:0] HI  = PW'(2**(DW-1) - 1);
  localparam logic signed [PW-1:0] LO  = -PW'(2**(DW-1));
  localparam logic signed [PW-1:0] RND = PW'(2**(TW_FRAC-1));

  logic signed [PW-1:0] sr, si, rr, ri;

  always_comb begin
    sr   = PW'(a_re) * PW'(w_re) - PW'(a_im) * PW'(w_im);
    si   = PW'(a_re) * PW'(w_im) + PW'(a_im) * PW'(w_re);
    rr   = (sr + RND) >>> TW_FRAC;
    ri   = (si + RND) >>> TW_FRAC;
    p_re = (rr > HI) ? HI[DW-1:0] : (rr < LO) ? LO[DW-1:0] : rr[DW-1:0];
    p_im = (ri > HI) ? HI[DW-1:0] : (ri < LO) ? LO[DW-1:0] : ri[DW-1:0];
  end
endmodule

// File: rtl/fft64_r4_stage.sv
module fft64_r4_stage import fft64_r4_pkg::*; #(
  parameter int STAGE = 0,
  parameter int DW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [IDX_W-1:0]     in_addr,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic [IDX_W-1:0]     out_tag
);
  localparam int WW = 2 * DW;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PTS - 1);

  logic [WW-1:0]    mem [0:1][0:PTS-1];
  logic [IDX_W-1:0] wcnt, wcnt_d, rcnt, rcnt_d;
  logic             wbank, wbank_d, rbank, rbank_d, rd_act, rd_act_d, wr_last;

  // next-state
  always_comb begin
    wr_last  = in_valid && (wcnt == LAST);
    wcnt_d   = in_valid ? wcnt + 1'b1 : wcnt;
    wbank_d  = wr_last ? ~wbank : wbank;
    rbank_d  = wr_last ? wbank : rbank;
    rd_act_d = wr_last ? 1'b1 : (rd_act && rcnt == LAST) ? 1'b0 : rd_act;
    rcnt_d   = wr_last ? '0 : rd_act ? rcnt + 1'b1 : rcnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0; wbank <= 1'b0; rbank <= 1'b0; rd_act <= 1'b0; rcnt <= '0;
    end else begin
      if (in_valid) wcnt <= wcnt_d;
      wbank  <= wbank_d;
      rbank  <= rbank_d;
      rd_act <= rd_act_d;
      rcnt   <= rcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) mem[wbank][in_addr] <= {in_re, in_im};
  end

  // read side: rcnt = {p, q, kk}, kk is the bin digit of this pass
  logic [1:0] p, q, kk;
  assign p  = rcnt[5:4];
  assign q  = rcnt[3:2];
  assign kk = rcnt[1:0];

  logic [3:0][DW-1:0] op_re, op_im;
  for (genvar m = 0; m < 4; m++) begin : g_op
    localparam logic [1:0] MD = 2'(m);
    logic [IDX_W-1:0] ra;
    logic [WW-1:0]    word;
    if (STAGE == 0) begin : g_a0
      assign ra = {MD, p, q};
    end else if (STAGE == 1) begin : g_a1
      assign ra = {q, MD, p};
    end else begin : g_a2
      assign ra = {q, p, MD};
    end
    assign word     = mem[rbank][ra];
    assign op_re[m] = word[WW-1:DW];
    assign op_im[m] = word[DW-1:0];
  end

  logic signed [DW-1:0] bf_re, bf_im, res_re, res_im;
  logic [IDX_W-1:0]     tag;

  fft64_r4_bfly #(.DW(DW)) u_bfly (
    .x_re(op_re), .x_im(op_im), .k(kk), .y_re(bf_re), .y_im(bf_im)
  );

  if (STAGE < NPASS - 1) begin : g_tw
    logic [IDX_W-1:0]      tw_e;
    logic [2*TW_W-1:0]     tw;
    if (STAGE == 0) begin : g_e16
      assign tw_e = {4'(p) * 4'(kk), 2'b00};
      assign tag  = {kk, p, q};
    end else begin : g_e64
      assign tw_e = 6'(p) * 6'({kk, q});
      assign tag  = {kk, q, p};
    end
    assign tw = tw64(tw_e);
    fft64_r4_cmul #(.DW(DW), .TW_W(TW_W), .TW_FRAC(TW_FRAC)) u_cmul (
      .a_re(bf_re), .a_im(bf_im),
      .w_re(tw[2*TW_W-1:TW_W]), .w_im(tw[TW_W-1:0]),
      .p_re(res_re), .p_im(res_im)
    );
  end else begin : g_plain
    assign res_re = bf_re;
    assign res_im = bf_im;
    assign tag    = {kk, q, p};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_re <= '0; out_im <= '0; out_tag <= '0;
    end else begin
      out_valid <= rd_act;
      if (rd_act) begin
        out_re  <= res_re;
        out_im  <= res_im;
        out_tag <= tag;
      end
    end
  end

  // R5: the bank being read is never the bank being written
  p_bank_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> (rbank != wbank));
  // R5: a full bank is handed over only when the previous read has finished
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> (!rd_act || rcnt == LAST));
endmodule

// File: rtl/fft64_r4_engine.sv
module fft64_r4_engine import fft64_r4_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im,
  output logic [IDX_W-1:0]         out_idx
);
  logic [IDX_W-1:0] ncnt, ncnt_d;

  always_comb ncnt_d = ncnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ncnt <= '0;
    else if (in_valid) ncnt <= ncnt_d;
  end

  logic [NPASS:0]                 v;
  logic [NPASS:0][DATA_W-1:0]     d_re, d_im;
  logic [NPASS:0][IDX_W-1:0]      d_ad;

  assign v[0]    = in_valid;
  assign d_re[0] = in_re;
  assign d_im[0] = in_im;
  assign d_ad[0] = ncnt;

  for (genvar g = 0; g < NPASS; g++) begin : g_pass
    fft64_r4_stage #(.STAGE(g), .DW(DATA_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (v[g]),
      .in_re    (d_re[g]),
      .in_im    (d_im[g]),
      .in_addr  (d_ad[g]),
      .out_valid(v[g+1]),
      .out_re   (d_re[g+1]),
      .out_im   (d_im[g+1]),
      .out_tag  (d_ad[g+1])
    );
  end

  assign out_valid = v[NPASS];
  assign out_re    = d_re[NPASS];
  assign out_im    = d_im[NPASS];
  assign out_idx   = d_ad[NPASS];

  // R3: consecutive results step through digit-reversed bin order
  p_bin_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |->
      (digit_rev(out_idx) == IDX_W'(digit_rev($past(out_idx)) + 1'b1)));
  // R5: a burst of results starts at the first bin of a frame
  p_frame_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (digit_rev(out_idx) == '0));
  // R5: a burst of results ends at the last bin of a frame
  p_frame_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (digit_rev($past(out_idx)) == '1));
endmodule

// File: tb/fft64_r4_engine_bench.sv
module fft64_r4_engine_bench;
  localparam int DW  = 16;
  localparam int TOL = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, out_valid;
  logic signed [DW-1:0] in_re, in_im, out_re, out_im;
  logic [5:0] out_idx;

  fft64_r4_engine #(.DATA_W(DW)) u_fft64_r4_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_idx(out_idx)
  );

  int xr [0:255];
  int xi [0:255];
  int orr[0:1023];
  int oii[0:1023];
  int okk[0:1023];
  int ocy[0:1023];
  int ocnt = 0, cyc = 0, t_first = 0, nchk = 0, nfail = 0, lcg = 12345;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && ocnt < 1024) begin
      orr[ocnt] = int'(out_re);
      oii[ocnt] = int'(out_im);
      okk[ocnt] = int'(out_idx);
      ocy[ocnt] = cyc;
      ocnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int drev(input int j);
    return ((j & 3) << 4) | (j & 12) | ((j >> 4) & 3);
  endfunction

  function automatic int rnd_val();
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >> 8) & 16'hFFFF) % 24001 - 12000;
  endfunction

  function automatic void ref_bin(input int f, input int k, output real rr, output real ri);
    rr = 0.0; ri = 0.0;
    for (int n = 0; n < 64; n++) begin
      real th;
      th = 2.0 * 3.14159265358979 * real'(n * k) / 64.0;
      rr += real'(xr[64*f+n]) * $cos(th) + real'(xi[64*f+n]) * $sin(th);
      ri += real'(xi[64*f+n]) * $cos(th) - real'(xr[64*f+n]) * $sin(th);
    end
    rr = rr / 64.0;
    ri = ri / 64.0;
  endfunction

  // mid_at/mid_len: idle cycles inside every frame; pre_len: idle cycles before frames after the first
  task automatic drive(input int nf, input int mid_at, input int mid_len, input int pre_len);
    for (int f = 0; f < nf; f++) begin
      for (int n = 0; n < 64; n++) begin
        if ((n == mid_at && mid_len > 0) || (n == 0 && f > 0 && pre_len > 0)) begin
          @(negedge clk);
          in_valid = 1'b0;
          repeat (((n == 0) ? pre_len : mid_len) - 1) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_re    = DW'(xr[64*f+n]);
        in_im    = DW'(xi[64*f+n]);
        if (f == 0 && n == 0) t_first = cyc;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_frames(input int base, input int nf, input string req);
    wait (ocnt >= base + 64 * nf);
    for (int f = 0; f < nf; f++) begin
      for (int j = 0; j < 64; j++) begin
        int i, k, er, ei;
        real rr, ri;
        i = base + 64 * f + j;
        k = drev(j);
        chk(okk[i] == k, "R3", "bin index", okk[i], k);
        ref_bin(f, k, rr, ri);
        er = int'(rr);
        ei = int'(ri);
        chk(orr[i] - er <= TOL && er - orr[i] <= TOL, req, $sformatf("real bin %0d", k), orr[i], er);
        chk(oii[i] - ei <= TOL && ei - oii[i] <= TOL, req, $sformatf("imag bin %0d", k), oii[i], ei);
      end
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_re = '0; in_im = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(out_idx == 6'd0, "R1", "out_idx in reset", int'(out_idx), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after release", int'(out_valid), 0);
    chk(out_idx == 6'd0, "R1", "out_idx after release", int'(out_idx), 0);
  endtask

  task automatic test_impulse();
    int base;
    for (int n = 0; n < 64; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 6400; xi[0] = -3200;
    base = ocnt;
    drive(1, -1, 0, 0);
    check_frames(base, 1, "R2");
    chk(ocy[base] - t_first == 195, "R4", "impulse latency", ocy[base] - t_first, 195);
  endtask

  task automatic test_tone();
    int base;
    for (int n = 0; n < 64; n++) begin
      real th;
      th = 2.0 * 3.14159265358979 * real'(5 * n) / 64.0;
      xr[n] = int'(8000.0 * $cos(th));
      xi[n] = int'(8000.0 * $sin(th));
    end
    base = ocnt;
    drive(1, -1, 0, 0);
    check_frames(base, 1, "R2");
    chk(orr[base + drev(5)] > 7990, "R2", "tone peak bin 5", orr[base + drev(5)], 8000);
  endtask

  task automatic test_stream();
    int base;
    for (int n = 0; n < 192; n++) begin xr[n] = rnd_val(); xi[n] = rnd_val(); end
    base = ocnt;
    drive(3, -1, 0, 0);
    check_frames(base, 3, "R5");
    chk(ocy[base] - t_first == 195, "R4", "stream latency", ocy[base] - t_first, 195);
    for (int i = 0; i < 191; i++)
      chk(ocy[base+i+1] - ocy[base+i] == 1, "R5", "output gap", ocy[base+i+1] - ocy[base+i], 1);
    repeat (10) @(negedge clk);
    chk(ocnt == base + 192, "R5", "result count", ocnt - base, 192);
  endtask

  task automatic test_fullscale();
    int base;
    for (int n = 0; n < 64; n++) begin
      xr[n] = 32767;  xi[n] = 0;
      xr[64+n] = 0;   xi[64+n] = -32768;
    end
    base = ocnt;
    drive(2, -1, 0, 0);
    check_frames(base, 2, "R6");
    chk(orr[base] == 32767, "R6", "positive full scale bin 0", orr[base], 32767);
    chk(oii[base+64] == -32768, "R6", "negative full scale bin 0", oii[base+64], -32768);
  endtask

  task automatic test_gaps();
    int base;
    for (int n = 0; n < 128; n++) begin xr[n] = rnd_val(); xi[n] = rnd_val(); end
    base = ocnt;
    drive(2, 20, 7, 5);
    check_frames(base, 2, "R7");
    repeat (10) @(negedge clk);
    chk(ocnt == base + 128, "R7", "result count with idle cycles", ocnt - base, 128);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    test_reset();
    test_impulse();
    test_tone();
    test_stream();
    test_fullscale();
    test_gaps();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R2 watchdog: actual %0d cycles, expected completion earlier", cyc);
    finish_run();
  end
endmodule